// File: doc/BRIEF.md
# Two-Level Branch Direction Predictor

This block guesses whether a branch at a given fetch address will be taken. It keeps a table of 2-bit entries. Each entry holds a predicted direction and a flag that records whether the last guess for that entry was wrong.

The table address has two parts. The upper part is a 2-bit global record of the most recent branch outcomes. The lower part is the word index taken from the fetch address. The global record therefore picks one of four banks of entries for the same address.

The fetch stage presents an address and reads the guess in the same cycle. It also reads the current history value and keeps it with the branch. When the branch resolves, the pipeline returns the address, the outcome and that saved history value on the update port. The update then writes the selected entry and shifts the outcome into the global record, both on the same clock edge.

Back-pressure on the update port works as follows:
- An update is accepted only in a cycle where `up_valid` and `up_ready` are both high.
- `up_ready` is low while reset is asserted. It rises on the first clock edge after reset is released and then stays high.
- A source that sees `up_ready` low must hold its request. No data is consumed in that cycle.

Top module: `tlbp_predictor`

## Requirements
- R1: While reset is asserted, every entry reads as not-taken with the wrong flag clear, the history reads 0 and `up_ready` is low. `up_ready` is high from the first clock edge after reset release.
- R2: The lookup index is fetch-address bits [IDX_W+1:2]. Bits [1:0] have no effect on the guess.
- R3: The table address is the history value concatenated above the address index, with the history in the upper bits. The same address under a different history reads an independent entry.
- R4: When the accepted outcome differs from the entry's guess and the entry's wrong flag is clear, the direction is kept and the wrong flag is set.
- R5: When the accepted outcome differs from the guess and the wrong flag is already set, the direction flips to the outcome and the flag clears.
- R6: When the accepted outcome matches the guess, the direction is kept and the flag clears. A later single miss then does not flip the entry.
- R7: Each accepted update shifts the history left by one, with the newest outcome (1 = taken) entering bit 0. `lk_hist` shows the new value from the next cycle on.
- R8: A lookup made in the same cycle as an update to the same entry returns the old guess. The written value is seen from the next clock on.
- R9: A cycle without an accepted update changes neither the table nor the history, whatever values sit on the other update inputs.
- R10: An update writes the bank given by `up_hist`, not the bank selected by the current history.
- R11: Address bits above IDX_W+1 are not used. Addresses that differ only there share an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Guess for `lk_pc` (1 = taken), combinational |
| lk_hist | output | HIST_W | Current global history, to be returned with the update |
| up_valid | input | 1 | Update request present |
| up_ready | output | 1 | Update can be accepted |
| up_pc | input | PC_W | Address of the resolved branch |
| up_hist | input | HIST_W | History value saved at lookup time |
| up_taken | input | 1 | Actual outcome (1 = taken) |

## Verification
A guess is combinational, so a lookup is compared a short settle delay after its address is driven, with no clock in between. An accepted update changes the entry and the history on the one edge that captures it. The bench therefore drives the update at a falling edge, drops it at the next falling edge and reads the effects only after that edge. The same-cycle case is read before the capturing edge, and the no-update case is read after several idle edges.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

  // One predictor entry: guessed direction plus "last guess was wrong" flag.
  typedef struct packed {
    logic dir;    // 1 = predict taken
    logic wrong;  // 1 = previous guess for this entry missed
  } ent_t;

  localparam ent_t ENT_RESET = '{dir: 1'b0, wrong: 1'b0};

endpackage

// File: rtl/tlbp_index.sv
module tlbp_index #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned HIST_W = 2
) (
  input  logic [PC_W-1:0]         pc,
  input  logic [HIST_W-1:0]       hist,
  output logic [IDX_W+HIST_W-1:0] idx
);
  localparam int unsigned LO = 2;
  localparam int unsigned HI = IDX_W + LO - 1;

  // History picks the bank, word-aligned address bits pick the row.
  assign idx = {hist, pc[HI:LO]};

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[LO-1:0], pc[PC_W-1:HI+1]};
endmodule

// File: rtl/tlbp_next.sv
module tlbp_next
  import tlbp_pkg::*;
(
  input  ent_t cur,
  input  logic taken,
  output ent_t nxt
);
  logic miss;
  assign miss = (cur.dir != taken);

  always_comb begin
    nxt = cur;
    if (!miss) begin
      nxt.wrong = 1'b0;
    end else if (!cur.wrong) begin
      nxt.wrong = 1'b1;
    end else begin
      nxt.dir   = taken;
      nxt.wrong = 1'b0;
    end
  end
endmodule

// File: rtl/tlbp_history.sv
module tlbp_history #(
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], outcome};
  end

  assign hist = hist_q;

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist_q[0] == $past(outcome)) && (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]))); // R7
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q)); // R9
endmodule

// File: rtl/tlbp_table.sv
module tlbp_table
  import tlbp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_a_idx,
  output ent_t              rd_a_ent,
  input  logic [ADDR_W-1:0] rd_b_idx,
  output ent_t              rd_b_ent,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  ent_t              wr_ent
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  ent_t ent_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ENT_RESET;
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_ent;
    end
  end

  assign rd_a_ent = ent_q[rd_a_idx];
  assign rd_b_ent = ent_q[rd_b_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_q[$past(wr_idx)] == $past(wr_ent))); // R8
endmodule

// File: rtl/tlbp_predictor.sv
module tlbp_predictor
  import tlbp_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [HIST_W-1:0] up_hist,
  input  logic              up_taken
);
  localparam int unsigned ADDR_W = IDX_W + HIST_W;

  logic              rdy_q;
  logic              up_fire;
  logic [HIST_W-1:0] cur_hist;
  logic [ADDR_W-1:0] lk_idx;
  logic [ADDR_W-1:0] up_idx;
  ent_t              lk_ent;
  ent_t              up_cur;
  ent_t              up_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign up_ready = rdy_q;
  assign up_fire  = up_valid & rdy_q;

  tlbp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_lk_index (
    .pc(lk_pc), .hist(cur_hist), .idx(lk_idx)
  );

  tlbp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_up_index (
    .pc(up_pc), .hist(up_hist), .idx(up_idx)
  );

  tlbp_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(up_fire), .outcome(up_taken), .hist(cur_hist)
  );

  tlbp_table #(.ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(lk_idx), .rd_a_ent(lk_ent),
    .rd_b_idx(up_idx), .rd_b_ent(up_cur),
    .wr_en(up_fire), .wr_idx(up_idx), .wr_ent(up_nxt)
  );

  tlbp_next u_next (
    .cur(up_cur), .taken(up_taken), .nxt(up_nxt)
  );

  assign lk_taken = lk_ent.dir;
  assign lk_hist  = cur_hist;

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |=> up_ready); // R1
  AST_FIRST_MISS_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fire && !up_cur.wrong) |-> (up_nxt.dir == up_cur.dir)); // R4
  AST_SECOND_MISS_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fire && up_cur.wrong && (up_cur.dir != up_taken)) |-> (up_nxt.dir == up_taken && !up_nxt.wrong)); // R5
  AST_HIT_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (up_fire && (up_cur.dir == up_taken)) |-> (!up_nxt.wrong && up_nxt.dir == up_taken)); // R6
  AST_IDLE_KEEPS_GUESS: assert property (@(posedge clk) disable iff (!rst_n)
    !up_fire |=> ($stable(lk_pc) -> $stable(lk_taken))); // R9
endmodule

// File: tb/tlbp_predictor_tb.sv
module tlbp_predictor_tb;
  localparam int CLK_P  = 10;
  localparam int PC_W   = 32;
  localparam int HIST_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [PC_W-1:0]   lk_pc = '0;
  logic              lk_taken;
  logic [HIST_W-1:0] lk_hist;
  logic              up_valid = 1'b0;
  logic              up_ready;
  logic [PC_W-1:0]   up_pc = '0;
  logic [HIST_W-1:0] up_hist = '0;
  logic              up_taken = 1'b0;

  int total = 0;
  int bad   = 0;

  localparam logic [PC_W-1:0] SCRATCH = 32'h100;

  tlbp_predictor #(.PC_W(PC_W), .IDX_W(6), .HIST_W(HIST_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
    .up_valid(up_valid), .up_ready(up_ready), .up_pc(up_pc), .up_hist(up_hist),
    .up_taken(up_taken)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic update(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h, input logic t);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_hist = h; up_taken = t;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic set_hist(input logic [1:0] h);
    update(SCRATCH, 2'd3, h[1]);
    update(SCRATCH, 2'd3, h[0]);
  endtask

  task automatic look(input string req, input logic [PC_W-1:0] pc, input logic exp);
    lk_pc = pc; #1;
    chk(req, int'(lk_taken), int'(exp));
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    chk("R1 ready in reset", int'(up_ready), 0);
    chk("R1 hist in reset", int'(lk_hist), 0);
    look("R1 entry in reset", 32'h40, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(up_ready), 1);
  endtask

  task automatic t_flip;  // R4 R5
    update(32'h40, 2'd0, 1'b1);
    set_hist(2'b00);
    look("R4 one miss keeps guess", 32'h40, 1'b0);
    update(32'h40, 2'd0, 1'b1);
    set_hist(2'b00);
    look("R5 second miss flips", 32'h40, 1'b1);
  endtask

  task automatic t_idle;  // R9
    @(negedge clk);
    up_valid = 1'b0; up_pc = 32'h40; up_hist = 2'd0; up_taken = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 hist unchanged", int'(lk_hist), 0);
    look("R9 entry unchanged", 32'h40, 1'b1);
  endtask

  task automatic t_alias;  // R2 R11
    look("R2 low bits ignored", 32'h43, 1'b1);
    look("R11 high bits alias", 32'h140, 1'b1);
    look("R2 other row untouched", 32'h44, 1'b0);
  endtask

  task automatic t_bank;  // R3
    set_hist(2'b01);
    look("R3 other bank independent", 32'h40, 1'b0);
  endtask

  task automatic t_clear;  // R6
    update(32'h80, 2'd0, 1'b1);
    update(32'h80, 2'd0, 1'b0);
    update(32'h80, 2'd0, 1'b1);
    set_hist(2'b00);
    look("R6 hit cleared flag", 32'h80, 1'b0);
  endtask

  task automatic t_same_cycle;  // R8
    @(negedge clk);
    up_valid = 1'b1; up_pc = 32'h80; up_hist = 2'd0; up_taken = 1'b1;
    look("R8 same-cycle old value", 32'h80, 1'b0);
    @(negedge clk);
    up_valid = 1'b0;
    set_hist(2'b00);
    look("R8 new value next clock", 32'h80, 1'b1);
  endtask

  task automatic t_saved_hist;  // R10
    update(32'hC0, 2'd2, 1'b1);
    update(32'hC0, 2'd2, 1'b1);
    set_hist(2'b00);
    look("R10 current bank untouched", 32'hC0, 1'b0);
    set_hist(2'b10);
    look("R10 supplied bank written", 32'hC0, 1'b1);
  endtask

  task automatic t_shift;  // R7
    set_hist(2'b00);
    update(SCRATCH, 2'd3, 1'b1);
    chk("R7 taken enters bit0", int'(lk_hist), 1);
    update(SCRATCH, 2'd3, 1'b0);
    chk("R7 shift left", int'(lk_hist), 2);
    update(SCRATCH, 2'd3, 1'b1);
    chk("R7 oldest drops out", int'(lk_hist), 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_flip();
    t_idle();
    t_alias();
    t_bank();
    t_clear();
    t_same_cycle();
    t_saved_hist();
    t_shift();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule